// File: doc/BRIEF.md
# Buddy Slab Allocator with Per-Class Free Stacks

This block hands out and takes back memory slabs for a key-value engine. Slabs come in five power-of-two size classes, from 32 bytes (class code 0) up to 512 bytes (class code 4). Each class has a small on-chip LIFO stack that holds the addresses of free slabs. An allocate request names a class and gets back an address. If that class is empty, a slab from the smallest larger non-empty class is cut in half, repeatedly, until the requested size is reached. A free request returns an address with its class. Before the slab is stacked, the block looks for its buddy in the same class and merges the two when it finds it.

The stacks are a cache in front of a much larger pool held in host memory. A pool port carries batch requests. It moves slab addresses into a stack, one beat at a time, when that stack runs low or when an allocate finds nothing anywhere. It moves the top entries out when a stack fills up. Only one allocate or free is in flight at a time, and split and merge cascades take one cycle per class step.

Top module: `slab_buddy_alloc`

## Requirements
- R1: After reset every stack is empty, both request ready outputs are high, and no response, pool request or spill beat is driven.
- R2: One request is accepted per cycle and alloc wins over free. Once a request has been accepted, both ready outputs stay low until its work is complete.
- R3: An allocate for a class whose stack holds entries returns that stack's most recently pushed address, with the error flag low.
- R4: When the requested class is empty, the top slab of the smallest larger non-empty class is taken. At each step down, its upper half (address plus the size of the lower class) is pushed onto the lower class, and the lower half at the original address is returned.
- R5: On a free at class c below 4, the stack of class c is searched for the buddy (address XOR 32<<c). If it is found, the buddy is removed, the address is cleared at bit position 5+c, and the check repeats at c+1. Otherwise the address is pushed onto class c. Class 4 never merges.
- R6: When no class at or above the requested one has an entry, a refill of the requested class is issued on the pool port. Its beats are pushed in arrival order, and after the beat marked last the search runs again.
- R7: If the search after that refill still finds nothing, or if the class code is 5 or higher, a response with the error flag high is given.
- R8: A pop that takes a stack from 4 entries to 3 causes a refill request of 8 entries for that class before the next request is accepted.
- R9: A push from a split or a merge that takes a stack from 12 entries to 13 causes a spill request for that class. Eight spill beats follow on consecutive cycles, giving the top entries newest first, and 5 entries remain.
- R10: A successful allocate response carries an address aligned to the size of the requested class, provided the pool supplies aligned addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocReqValid | input | 1 | Allocate request present |
| allocReqReady | output | 1 | Allocate request accepted this cycle |
| allocClass | input | 3 | Requested class code, 0 = 32 B to 4 = 512 B |
| allocRespValid | output | 1 | Allocate result strobe, one cycle |
| allocAddr | output | 16 | Allocated slab byte address |
| allocErr | output | 1 | No slab could be found |
| freeValid | input | 1 | Free request present |
| freeReady | output | 1 | Free request accepted this cycle |
| freeAddr | input | 16 | Address of the slab being returned |
| freeClass | input | 3 | Class code of the slab being returned |
| poolReqValid | output | 1 | Batch request to the host pool |
| poolReqReady | input | 1 | Pool takes the batch request |
| poolReqSpill | output | 1 | 1 = spill batch, 0 = refill batch |
| poolReqClass | output | 3 | Class of the batch |
| poolReqCount | output | 5 | Number of entries in the batch |
| poolFillValid | input | 1 | Refill beat present |
| poolFillAddr | input | 16 | Refill slab address |
| poolFillLast | input | 1 | Final beat of the refill batch |
| poolFillEmpty | input | 1 | Beat carries no address (pool exhausted) |
| poolSpillValid | output | 1 | Spill beat present |
| poolSpillAddr | output | 16 | Spilled slab address |

## Verification
The assertions check on every cycle that a request never overlaps with busy work. They also check that response, pool request and spill beat never coincide, that a spill burst never exceeds its batch length, that successful responses are aligned to the requested size, and that bad class codes always answer with an error. Which address comes back, and in what order, can only be shown by the bench's scenarios. That covers LIFO order, the halves produced by a split cascade, a four-level merge cascade rebuilding a 512-byte slab, the low-water and high-water pool traffic, and the error after an empty refill.

// File: rtl/slab_pkg.sv
package slab_pkg;
  localparam int ADDR_W      = 16;
  localparam int NUM_CLS     = 5;
  localparam int CLS_W       = $clog2(NUM_CLS);
  localparam int STACK_DEPTH = 16;
  localparam int IDX_W       = $clog2(STACK_DEPTH);
  localparam int CNT_W       = $clog2(STACK_DEPTH + 1);
  localparam int MIN_SLAB    = 32;

  typedef struct packed {
    logic              push;
    logic              pop;
    logic              remove;
    logic [CLS_W-1:0]  cls;
    logic [ADDR_W-1:0] addr;
    logic [IDX_W-1:0]  idx;
  } stack_op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_SEARCH, S_SPLIT, S_MERGE,
    S_FILL_REQ, S_FILL_WAIT, S_SPILL_REQ, S_SPILL_OUT
  } ctrl_state_t;

  function automatic logic [ADDR_W-1:0] sizeOf(input logic [CLS_W-1:0] c);
    return ADDR_W'(MIN_SLAB) << c;
  endfunction
endpackage

// File: rtl/slab_stack_bank.sv
module slab_stack_bank
  import slab_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  stack_op_t                        op,
  input  logic [ADDR_W-1:0]                lookupAddr,
  input  logic [CLS_W-1:0]                 lookupCls,
  output logic                             buddyHit,
  output logic [IDX_W-1:0]                 buddyIdx,
  output logic [NUM_CLS-1:0][CNT_W-1:0]    count,
  output logic [NUM_CLS-1:0][ADDR_W-1:0]   topAddr
);
  logic [ADDR_W-1:0] buddyAddr;
  logic [NUM_CLS-1:0][STACK_DEPTH-1:0] matchVec;

  assign buddyAddr = lookupAddr ^ sizeOf(lookupCls);

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    logic [ADDR_W-1:0] mem [STACK_DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic              sel;

    assign sel = (op.cls == CLS_W'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt <= '0;
      else if (sel) begin
        if (op.push) cnt <= cnt + 1'b1;
        else if (op.pop || op.remove) cnt <= cnt - 1'b1;
      end
    end

    // removal closes the gap by shifting the upper entries down one slot
    always_ff @(posedge clk) begin
      if (sel) begin
        if (op.push) mem[cnt[IDX_W-1:0]] <= op.addr;
        else if (op.remove) begin
          for (int j = 0; j < STACK_DEPTH - 1; j++)
            if (IDX_W'(j) >= op.idx) mem[j] <= mem[j+1];
        end
      end
    end

    assign count[k]   = cnt;
    assign topAddr[k] = mem[IDX_W'(cnt - 1'b1)];

    for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_cmp
      assign matchVec[k][i] = (CNT_W'(i) < cnt) && (mem[i] == buddyAddr);
    end
  end

  always_comb begin
    buddyHit = 1'b0;
    buddyIdx = '0;
    for (int i = STACK_DEPTH - 1; i >= 0; i--) begin
      if (matchVec[lookupCls][i]) begin
        buddyHit = 1'b1;
        buddyIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/slab_alloc_ctrl.sv
module slab_alloc_ctrl
  import slab_pkg::*;
#(
  parameter int LOW_MARK     = 4,
  parameter int HIGH_MARK    = 12,
  parameter int REFILL_BATCH = 8,
  parameter int SPILL_BATCH  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           allocReqValid,
  output logic                           allocReqReady,
  input  logic [CLS_W-1:0]               allocClass,
  output logic                           allocRespValid,
  output logic [ADDR_W-1:0]              allocAddr,
  output logic                           allocErr,
  input  logic                           freeValid,
  output logic                           freeReady,
  input  logic [ADDR_W-1:0]              freeAddr,
  input  logic [CLS_W-1:0]               freeClass,
  output logic                           poolReqValid,
  input  logic                           poolReqReady,
  output logic                           poolReqSpill,
  output logic [CLS_W-1:0]               poolReqClass,
  output logic [CNT_W-1:0]               poolReqCount,
  input  logic                           poolFillValid,
  input  logic [ADDR_W-1:0]              poolFillAddr,
  input  logic                           poolFillLast,
  input  logic                           poolFillEmpty,
  output logic                           poolSpillValid,
  output logic [ADDR_W-1:0]              poolSpillAddr,
  output stack_op_t                      op,
  output logic [ADDR_W-1:0]              lookupAddr,
  output logic [CLS_W-1:0]               lookupCls,
  input  logic                           buddyHit,
  input  logic [IDX_W-1:0]               buddyIdx,
  input  logic [NUM_CLS-1:0][CNT_W-1:0]  count,
  input  logic [NUM_CLS-1:0][ADDR_W-1:0] topAddr
);
  ctrl_state_t        st;
  logic [CLS_W-1:0]   reqCls, curCls, xferCls, srcCls, pickSpill, pickFill, halfCls;
  logic [ADDR_W-1:0]  curAddr;
  logic               tried, fillForAlloc, srcFound, canMerge;
  logic [CNT_W-1:0]   spillLeft;
  logic [NUM_CLS-1:0] pendFill, pendSpill;

  assign halfCls  = CLS_W'(curCls - 1'b1);
  assign canMerge = (curCls < CLS_W'(NUM_CLS - 1)) && buddyHit;

  always_comb begin
    srcFound = 1'b0; srcCls = '0; pickSpill = '0; pickFill = '0;
    for (int k = NUM_CLS - 1; k >= 0; k--) begin
      if (CLS_W'(k) >= reqCls && count[k] != '0) begin srcFound = 1'b1; srcCls = CLS_W'(k); end
      if (pendSpill[k]) pickSpill = CLS_W'(k);
      if (pendFill[k])  pickFill  = CLS_W'(k);
    end
  end

  assign allocReqReady = (st == S_IDLE) && !(|pendFill) && !(|pendSpill);
  assign freeReady     = allocReqReady && !allocReqValid;
  assign lookupAddr    = curAddr;
  assign lookupCls     = curCls;
  assign poolReqClass  = xferCls;
  assign poolSpillAddr = topAddr[xferCls];

  always_comb begin
    op = '0;
    allocRespValid = 1'b0; allocAddr = '0; allocErr = 1'b0;
    poolReqValid = 1'b0; poolReqSpill = 1'b0; poolSpillValid = 1'b0;
    poolReqCount = CNT_W'(REFILL_BATCH);
    case (st)
      S_SEARCH: begin
        if (reqCls >= CLS_W'(NUM_CLS)) begin
          allocRespValid = 1'b1; allocErr = 1'b1;
        end else if (srcFound) begin
          op.pop = 1'b1; op.cls = srcCls;
          if (srcCls == reqCls) begin allocRespValid = 1'b1; allocAddr = topAddr[srcCls]; end
        end else if (tried) begin
          allocRespValid = 1'b1; allocErr = 1'b1;
        end
      end
      S_SPLIT: begin
        op.push = 1'b1; op.cls = halfCls; op.addr = curAddr + sizeOf(halfCls);
        if (halfCls == reqCls) begin allocRespValid = 1'b1; allocAddr = curAddr; end
      end
      S_MERGE: begin
        op.cls = curCls; op.addr = curAddr; op.idx = buddyIdx;
        if (canMerge) op.remove = 1'b1;
        else          op.push   = 1'b1;
      end
      S_FILL_REQ:  poolReqValid = 1'b1;
      S_FILL_WAIT: begin
        op.push = poolFillValid && !poolFillEmpty; op.cls = xferCls; op.addr = poolFillAddr;
      end
      S_SPILL_REQ: begin
        poolReqValid = 1'b1; poolReqSpill = 1'b1; poolReqCount = CNT_W'(SPILL_BATCH);
      end
      S_SPILL_OUT: begin
        poolSpillValid = 1'b1; op.pop = 1'b1; op.cls = xferCls;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; reqCls <= '0; curCls <= '0; curAddr <= '0; xferCls <= '0;
      tried <= 1'b0; fillForAlloc <= 1'b0; spillLeft <= '0;
      pendFill <= '0; pendSpill <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (|pendSpill) begin
            xferCls <= pickSpill; pendSpill[pickSpill] <= 1'b0;
            spillLeft <= CNT_W'(SPILL_BATCH); st <= S_SPILL_REQ;
          end else if (|pendFill) begin
            xferCls <= pickFill; pendFill[pickFill] <= 1'b0;
            fillForAlloc <= 1'b0; st <= S_FILL_REQ;
          end else if (allocReqValid) begin
            reqCls <= allocClass; tried <= 1'b0; st <= S_SEARCH;
          end else if (freeValid && freeClass < CLS_W'(NUM_CLS)) begin
            curAddr <= freeAddr; curCls <= freeClass; st <= S_MERGE;
          end
        end
        S_SEARCH: begin
          if (reqCls >= CLS_W'(NUM_CLS)) st <= S_IDLE;
          else if (srcFound) begin
            if (srcCls == reqCls) st <= S_IDLE;
            else begin curAddr <= topAddr[srcCls]; curCls <= srcCls; st <= S_SPLIT; end
          end else if (tried) st <= S_IDLE;
          else begin
            xferCls <= reqCls; fillForAlloc <= 1'b1; tried <= 1'b1; st <= S_FILL_REQ;
          end
        end
        S_SPLIT: begin
          curCls <= halfCls;
          if (halfCls == reqCls) st <= S_IDLE;
        end
        S_MERGE: begin
          if (canMerge) begin
            curAddr <= curAddr & ~sizeOf(curCls);
            curCls  <= CLS_W'(curCls + 1'b1);
          end else st <= S_IDLE;
        end
        S_FILL_REQ:  if (poolReqReady) st <= S_FILL_WAIT;
        S_FILL_WAIT: if (poolFillValid && poolFillLast) st <= fillForAlloc ? S_SEARCH : S_IDLE;
        S_SPILL_REQ: if (poolReqReady) st <= S_SPILL_OUT;
        S_SPILL_OUT: begin
          spillLeft <= spillLeft - 1'b1;
          if (spillLeft == CNT_W'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (op.pop && st != S_SPILL_OUT && count[op.cls] == CNT_W'(LOW_MARK))
        pendFill[op.cls] <= 1'b1;
      if (op.push && (st == S_SPLIT || st == S_MERGE) && count[op.cls] == CNT_W'(HIGH_MARK))
        pendSpill[op.cls] <= 1'b1;
    end
  end
endmodule

// File: rtl/slab_buddy_alloc.sv
module slab_buddy_alloc
  import slab_pkg::*;
#(
  parameter int LOW_MARK     = 4,
  parameter int HIGH_MARK    = 12,
  parameter int REFILL_BATCH = 8,
  parameter int SPILL_BATCH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocReqValid,
  output logic              allocReqReady,
  input  logic [CLS_W-1:0]  allocClass,
  output logic              allocRespValid,
  output logic [ADDR_W-1:0] allocAddr,
  output logic              allocErr,
  input  logic              freeValid,
  output logic              freeReady,
  input  logic [ADDR_W-1:0] freeAddr,
  input  logic [CLS_W-1:0]  freeClass,
  output logic              poolReqValid,
  input  logic              poolReqReady,
  output logic              poolReqSpill,
  output logic [CLS_W-1:0]  poolReqClass,
  output logic [CNT_W-1:0]  poolReqCount,
  input  logic              poolFillValid,
  input  logic [ADDR_W-1:0] poolFillAddr,
  input  logic              poolFillLast,
  input  logic              poolFillEmpty,
  output logic              poolSpillValid,
  output logic [ADDR_W-1:0] poolSpillAddr
);
  stack_op_t                      op;
  logic [ADDR_W-1:0]              lookupAddr;
  logic [CLS_W-1:0]               lookupCls;
  logic                           buddyHit;
  logic [IDX_W-1:0]               buddyIdx;
  logic [NUM_CLS-1:0][CNT_W-1:0]  count;
  logic [NUM_CLS-1:0][ADDR_W-1:0] topAddr;

  slab_alloc_ctrl #(
    .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK),
    .REFILL_BATCH(REFILL_BATCH), .SPILL_BATCH(SPILL_BATCH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocReqValid(allocReqValid), .allocReqReady(allocReqReady), .allocClass(allocClass),
    .allocRespValid(allocRespValid), .allocAddr(allocAddr), .allocErr(allocErr),
    .freeValid(freeValid), .freeReady(freeReady), .freeAddr(freeAddr), .freeClass(freeClass),
    .poolReqValid(poolReqValid), .poolReqReady(poolReqReady), .poolReqSpill(poolReqSpill),
    .poolReqClass(poolReqClass), .poolReqCount(poolReqCount),
    .poolFillValid(poolFillValid), .poolFillAddr(poolFillAddr),
    .poolFillLast(poolFillLast), .poolFillEmpty(poolFillEmpty),
    .poolSpillValid(poolSpillValid), .poolSpillAddr(poolSpillAddr),
    .op(op), .lookupAddr(lookupAddr), .lookupCls(lookupCls),
    .buddyHit(buddyHit), .buddyIdx(buddyIdx), .count(count), .topAddr(topAddr)
  );

  slab_stack_bank u_bank (
    .clk(clk), .rstN(rstN), .op(op), .lookupAddr(lookupAddr), .lookupCls(lookupCls),
    .buddyHit(buddyHit), .buddyIdx(buddyIdx), .count(count), .topAddr(topAddr)
  );
endmodule

// File: rtl/slab_alloc_chk.sv
module slab_alloc_chk
  import slab_pkg::*;
#(
  parameter int SPILL_BATCH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              allocReqValid,
  input logic              allocReqReady,
  input logic [CLS_W-1:0]  allocClass,
  input logic              allocRespValid,
  input logic [ADDR_W-1:0] allocAddr,
  input logic              allocErr,
  input logic              freeReady,
  input logic              poolReqValid,
  input logic              poolSpillValid
);
  logic [CLS_W-1:0] seenCls;
  logic [CNT_W-1:0] spillRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenCls <= '0; spillRun <= '0;
    end else begin
      if (allocReqValid && allocReqReady) seenCls <= allocClass;
      spillRun <= poolSpillValid ? spillRun + 1'b1 : '0;
    end
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocReqValid && allocReqReady) |=> (!allocReqReady && !freeReady));

  // R2
  single_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({allocRespValid, poolReqValid, poolSpillValid}));

  // R9
  spill_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    poolSpillValid |-> (spillRun < CNT_W'(SPILL_BATCH)));

  // R10
  aligned_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocRespValid && !allocErr && seenCls < CLS_W'(NUM_CLS))
      |-> ((allocAddr & (sizeOf(seenCls) - 1'b1)) == '0));

  // R7
  bad_class_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocRespValid && seenCls >= CLS_W'(NUM_CLS)) |-> allocErr);
endmodule

bind slab_buddy_alloc slab_alloc_chk #(.SPILL_BATCH(SPILL_BATCH)) u_chk (
  .clk(clk), .rstN(rstN), .allocReqValid(allocReqValid), .allocReqReady(allocReqReady),
  .allocClass(allocClass), .allocRespValid(allocRespValid), .allocAddr(allocAddr),
  .allocErr(allocErr), .freeReady(freeReady), .poolReqValid(poolReqValid),
  .poolSpillValid(poolSpillValid)
);

// File: tb/test_slab_buddy_alloc.sv
module test_slab_buddy_alloc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocReqValid = 1'b0, allocReqReady;
  logic [2:0]  allocClass = '0;
  logic        allocRespValid, allocErr;
  logic [15:0] allocAddr;
  logic        freeValid = 1'b0, freeReady;
  logic [15:0] freeAddr = '0;
  logic [2:0]  freeClass = '0;
  logic        poolReqValid, poolReqSpill;
  logic        poolReqReady = 1'b1;
  logic [2:0]  poolReqClass;
  logic [4:0]  poolReqCount;
  logic        poolFillValid = 1'b0, poolFillLast = 1'b0, poolFillEmpty = 1'b0;
  logic [15:0] poolFillAddr = '0;
  logic        poolSpillValid;
  logic [15:0] poolSpillAddr;

  always #2.5 clk = ~clk;

  slab_buddy_alloc i_slab_buddy_alloc (.*);

  int checks = 0, fails = 0, fillReq0 = 0;
  logic [15:0] expAddr[$];
  logic        expErr[$];
  string       expTag[$];
  logic [15:0] spillQ[$];
  logic [15:0] poolMem[5][8];
  int          poolCnt[5];

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (allocRespValid) begin
      if (expAddr.size() == 0) chk(1'b0, "R2 unexpected response", allocAddr, 16'hxxxx);
      else begin
        logic [15:0] ea; logic ee; string t;
        ea = expAddr.pop_front(); ee = expErr.pop_front(); t = expTag.pop_front();
        chk(allocErr == ee, {t, " err"}, {15'd0, allocErr}, {15'd0, ee});
        if (!ee) chk(allocAddr == ea, {t, " addr"}, allocAddr, ea);
      end
    end
    if (poolSpillValid) begin
      if (spillQ.size() == 0) chk(1'b0, "R9 unexpected spill", poolSpillAddr, 16'hxxxx);
      else begin
        logic [15:0] es;
        es = spillQ.pop_front();
        chk(poolSpillAddr == es, "R9 spill beat", poolSpillAddr, es);
      end
    end
    if (poolReqValid && !poolReqSpill && poolReqClass == 3'd0) fillReq0++;
  end

  // host pool model: answers each refill request with its stored batch
  initial forever begin
    @(negedge clk);
    if (poolReqValid && !poolReqSpill) begin
      int c, n;
      c = int'(poolReqClass); n = poolCnt[c];
      @(posedge clk);
      if (n == 0) begin
        @(negedge clk); poolFillValid = 1'b1; poolFillEmpty = 1'b1; poolFillLast = 1'b1;
      end else begin
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          poolFillValid = 1'b1; poolFillEmpty = 1'b0;
          poolFillAddr = poolMem[c][i]; poolFillLast = (i == n - 1);
        end
      end
      poolCnt[c] = 0;
      @(negedge clk); poolFillValid = 1'b0; poolFillLast = 1'b0; poolFillEmpty = 1'b0;
    end
  end

  task automatic doAlloc(input logic [2:0] c, input logic [15:0] ea, input logic ee, input string tag);
    expAddr.push_back(ea); expErr.push_back(ee); expTag.push_back(tag);
    @(negedge clk);
    allocClass = c; allocReqValid = 1'b1;
    while (!allocReqReady) @(negedge clk);
    @(posedge clk); #1;
    allocReqValid = 1'b0;
    chk(!allocReqReady && !freeReady, "R2 ready low after accept", {15'd0, allocReqReady}, 16'd0);
    while (expAddr.size() != 0) @(negedge clk);
  endtask

  task automatic doFree(input logic [15:0] a, input logic [2:0] c);
    @(negedge clk);
    freeAddr = a; freeClass = c; freeValid = 1'b1;
    while (!freeReady) @(negedge clk);
    @(posedge clk); #1;
    freeValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5; c++) poolCnt[c] = 0;
    poolMem[4][0] = 16'h1000; poolMem[4][1] = 16'h1200;
    poolMem[4][2] = 16'h1400; poolMem[4][3] = 16'h1600; poolCnt[4] = 4;
    poolMem[0][0] = 16'h3000; poolMem[0][1] = 16'h3040; poolCnt[0] = 2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(allocReqReady && freeReady, "R1 ready after reset", {14'd0, allocReqReady, freeReady}, 16'd3);
    chk(!allocRespValid && !poolReqValid && !poolSpillValid, "R1 idle outputs",
        {13'd0, allocRespValid, poolReqValid, poolSpillValid}, 16'd0);

    // R6 empty stacks: refill class 4 then LIFO pop of newest (R3)
    doAlloc(3'd4, 16'h1600, 1'b0, "R6 refill then alloc");
    // R4 split 512-byte slab down to 32 bytes
    doAlloc(3'd0, 16'h1400, 1'b0, "R4 split cascade");
    doAlloc(3'd1, 16'h1440, 1'b0, "R4 upper half pushed on class1");
    // R5 merge cascade rebuilds 0x1400 at class 4
    doFree(16'h1400, 3'd0);
    doFree(16'h1440, 3'd1);
    doAlloc(3'd4, 16'h1400, 1'b0, "R5 merged slab on class4 top");
    doAlloc(3'd3, 16'h1200, 1'b0, "R4 split 512 to 256");
    doAlloc(3'd3, 16'h1300, 1'b0, "R3 class3 holds upper half");
    doAlloc(3'd4, 16'h1000, 1'b0, "R3 last class4 entry");
    // R7 empty everywhere, pool empty
    doAlloc(3'd4, 16'h0000, 1'b1, "R7 exhausted");
    doAlloc(3'd5, 16'h0000, 1'b1, "R7 bad class code");

    // R9 push 13 non-buddy slabs into class 0
    for (int k = 5; k <= 12; k++) spillQ.push_front(16'h2000 + 16'(k) * 16'h40);
    for (int k = 0; k <= 12; k++) doFree(16'h2000 + 16'(k) * 16'h40, 3'd0);
    while (spillQ.size() != 0) @(negedge clk);
    doAlloc(3'd0, 16'h2100, 1'b0, "R9 five entries remain");

    // R8 pop from 4 to 3 triggers refill of class 0
    doAlloc(3'd0, 16'h20C0, 1'b0, "R3 class0 pop");
    doAlloc(3'd0, 16'h3040, 1'b0, "R8 low-water refill");
    chk(fillReq0 == 1, "R8 refill request count", 16'(fillReq0), 16'd1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule